// File: doc/BRIEF.md
# Sparse Hit-Pattern Row Buffer

The block watches one row of 42 binary pixel outputs and keeps a compact record of which pixels fired. On each accepted sample strobe it freezes the synchronised, masked hit flags together with the externally supplied timestamp. It then walks the row as seven six-pixel groups, one group per clock. Any group with a set bit is written to the next free slot of a 19-entry register file. The entry holds the six-bit pattern, the group number and the timestamp. A dense cluster therefore costs at most seven slots per sample, and an isolated noise hit costs one.

A single one-hot token marks the next free slot and moves up by one on each write. During readout the same token walks back down through the written slots. Readout is a valid/ready stream. Each word carries a fixed per-instance row address above the slot contents, and a last flag on the final word. When the file is full, later entries are dropped and a sticky overflow flag is raised. An override input stores every group regardless of hits, which lets arbitrary timestamps exercise the storage. A clear input empties the file.

Top module: `hit_row_buffer`

## Requirements
- R1: `hit_in` passes through a two-flop synchroniser. An accepted strobe latches the synchronised flags, so an input held steady for at least two clocks before the strobe edge is captured. `ts_in` is latched on the same edge.
- R2: After an accepted strobe, groups 0 to 6 are examined in ascending order, one per clock. Group g covers pixels 6g to 6g+5, and the first write lands on the clock edge after the strobe edge.
- R3: A stored entry has this layout: bits [21:9] are the latched timestamp, bits [8:3] are the group pattern, and bits [2:0] are the group number. Pattern bit k is pixel 6g+k.
- R4: A strobe is ignored while a scan is running (the 7 edges after an accepted strobe) and while a readout is in progress. Strobes can therefore be accepted at most once every 8 clocks.
- R5: At most 19 entries are kept. The first 19 are retained and later ones are dropped. A dropped entry sets `overflow`, which stays high until clear.
- R6: The slot pointer always holds exactly one set bit.
- R7: `rd_start` starts a readout. Words are sent last-written first, down to slot 0, each as {ROW_ADDR, entry}, with `out_last` high on the slot-0 word. A readout drains the buffer.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold steady.
- R9: If the buffer is empty, `rd_done` pulses on the clock after `rd_start` and no word is sent.
- R10: With `override_en` high during a scan, all seven groups are stored, including groups with pattern 0.
- R11: `mask_we` loads `mask_wdata` into the pixel mask, and `mask_rdata` returns it. A masked pixel contributes 0 to its group. A group whose only hits are masked is not stored.
- R12: `clear` empties the buffer, ends any readout and clears `overflow`.
- R13: After the handshake of the last word, `rd_done` is high for exactly the next cycle and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hit_in | input | 42 | Asynchronous pixel hit flags |
| sample | input | 1 | Sample strobe |
| ts_in | input | 13 | Timestamp, latched with the sample |
| override_en | input | 1 | Store every group during a scan |
| mask_we | input | 1 | Load the pixel mask |
| mask_wdata | input | 42 | New mask, 1 = pixel masked |
| mask_rdata | output | 42 | Current mask |
| clear | input | 1 | Empty the buffer and clear overflow |
| rd_start | input | 1 | Start a readout |
| out_valid | output | 1 | Readout word valid |
| out_ready | input | 1 | Readout word accepted |
| out_data | output | 30 | {row address[7:0], entry[21:0]} |
| out_last | output | 1 | Final word of the readout |
| rd_done | output | 1 | One-cycle end-of-readout pulse |
| overflow | output | 1 | Sticky entry-dropped flag |

## Verification
Hit inputs are changed three clocks before a strobe, which leaves room for the two synchroniser flops. Every scan is then given at least eight clocks before a readout. Words are taken on the negative edge while `out_valid` is high, and each counts as transferred at the following rising edge. `rd_done` is expected one negative edge after that final edge, or one cycle after `rd_start` when the buffer is empty. Ignored strobes are timed at the 3rd and 7th edges of a scan and during a stalled readout. The effect of each is then read back through a later readout.

// File: rtl/hrb_pkg.sv
package hrb_pkg;
  typedef enum logic {RD_IDLE, RD_XFER} rd_state_e;
endpackage

// File: rtl/hrb_sync.sv
module hrb_sync #(
  parameter int W = 42
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      d_out  <= '0;
    end else begin
      stage1 <= d_in;
      d_out  <= stage1;
    end
  end
endmodule

// File: rtl/hrb_scan.sv
module hrb_scan #(
  parameter int NPIX  = 42,
  parameter int GRP_W = 6,
  parameter int TS_W  = 13,
  localparam int NGRP   = NPIX / GRP_W,
  localparam int GIDX_W = $clog2(NGRP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              start,
  input  logic              override_en,
  input  logic [NPIX-1:0]   hits,
  input  logic [NPIX-1:0]   mask,
  input  logic [TS_W-1:0]   ts_in,
  output logic              busy,
  output logic              wr_en,
  output logic [GRP_W-1:0]  wr_pat,
  output logic [GIDX_W-1:0] wr_gidx,
  output logic [TS_W-1:0]   wr_ts
);
  localparam logic [GIDX_W-1:0] LAST_G = GIDX_W'(NGRP - 1);

  logic [NPIX-1:0] frozen;

  function automatic logic [GRP_W-1:0] group_bits(input logic [NPIX-1:0] v,
                                                  input logic [GIDX_W-1:0] g);
    return v[g*GRP_W +: GRP_W];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frozen  <= '0;
      wr_ts   <= '0;
      busy    <= 1'b0;
      wr_gidx <= '0;
    end else if (clear) begin
      busy    <= 1'b0;
      wr_gidx <= '0;
    end else if (start) begin
      frozen  <= hits & ~mask;
      wr_ts   <= ts_in;
      busy    <= 1'b1;
      wr_gidx <= '0;
    end else if (busy) begin
      if (wr_gidx == LAST_G) busy <= 1'b0;
      else wr_gidx <= wr_gidx + 1'b1;
    end
  end

  assign wr_pat = group_bits(frozen, wr_gidx);
  assign wr_en  = busy && (override_en || (wr_pat != '0));

  assert_scan_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_gidx == LAST_G && !clear |=> !busy);
  assert_scan_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_gidx != LAST_G && !clear |=> busy && wr_gidx == $past(wr_gidx) + 1'b1);
  assert_group_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_gidx <= LAST_G);
endmodule

// File: rtl/hrb_slots.sv
module hrb_slots
  import hrb_pkg::*;
#(
  parameter int SLOTS   = 19,
  parameter int ENTRY_W = 22,
  parameter int ROW_W   = 8,
  parameter logic [ROW_W-1:0] ROW_ADDR = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     wr_en,
  input  logic [ENTRY_W-1:0]       wr_entry,
  input  logic                     rd_start,
  input  logic                     out_ready,
  output logic                     reading,
  output logic                     overflow,
  output logic                     out_valid,
  output logic [ROW_W+ENTRY_W-1:0] out_data,
  output logic                     out_last,
  output logic                     rd_done
);
  rd_state_e          st;
  logic [SLOTS:0]     tok;
  logic [ENTRY_W-1:0] mem [SLOTS];
  logic [ENTRY_W-1:0] rd_word;
  logic               wr_ok;
  logic               full;

  assign full  = tok[SLOTS];
  assign wr_ok = wr_en && (st == RD_IDLE) && !clear && !full;

  always_ff @(posedge clk) begin
    for (int i = 0; i < SLOTS; i++)
      if (wr_ok && tok[i]) mem[i] <= wr_entry;
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < SLOTS; i++)
      if (tok[i]) rd_word |= mem[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok      <= (SLOTS+1)'(1);
      st       <= RD_IDLE;
      overflow <= 1'b0;
      rd_done  <= 1'b0;
    end else if (clear) begin
      tok      <= (SLOTS+1)'(1);
      st       <= RD_IDLE;
      overflow <= 1'b0;
      rd_done  <= 1'b0;
    end else begin
      rd_done <= 1'b0;
      case (st)
        RD_IDLE: begin
          if (wr_en) begin
            if (full) overflow <= 1'b1;
            else tok <= tok << 1;
          end else if (rd_start) begin
            if (tok[0]) rd_done <= 1'b1;
            else begin
              tok <= tok >> 1;
              st  <= RD_XFER;
            end
          end
        end
        default: begin
          if (out_ready) begin
            if (tok[0]) begin
              st      <= RD_IDLE;
              rd_done <= 1'b1;
            end else tok <= tok >> 1;
          end
        end
      endcase
    end
  end

  assign reading   = (st == RD_XFER);
  assign out_valid = reading;
  assign out_last  = reading && tok[0];
  assign out_data  = {ROW_ADDR, rd_word};

  assert_token_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tok) == 1);
  assert_overflow_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !clear |=> overflow);
  assert_drop_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && full && st == RD_IDLE && !clear |=> overflow);
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !clear |=> out_valid && $stable(out_data));
  assert_done_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> !out_valid);
endmodule

// File: rtl/hit_row_buffer.sv
module hit_row_buffer #(
  parameter int NPIX  = 42,
  parameter int GRP_W = 6,
  parameter int SLOTS = 19,
  parameter int TS_W  = 13,
  parameter int ROW_W = 8,
  parameter logic [ROW_W-1:0] ROW_ADDR = 8'h2A,
  localparam int NGRP    = NPIX / GRP_W,
  localparam int GIDX_W  = $clog2(NGRP),
  localparam int ENTRY_W = TS_W + GRP_W + GIDX_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPIX-1:0]          hit_in,
  input  logic                     sample,
  input  logic [TS_W-1:0]          ts_in,
  input  logic                     override_en,
  input  logic                     mask_we,
  input  logic [NPIX-1:0]          mask_wdata,
  output logic [NPIX-1:0]          mask_rdata,
  input  logic                     clear,
  input  logic                     rd_start,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [ROW_W+ENTRY_W-1:0] out_data,
  output logic                     out_last,
  output logic                     rd_done,
  output logic                     overflow
);
  logic [NPIX-1:0]   hits_sync;
  logic [NPIX-1:0]   mask_q;
  logic              scan_busy, reading, sample_ok, rd_go;
  logic              wr_en;
  logic [GRP_W-1:0]  wr_pat;
  logic [GIDX_W-1:0] wr_gidx;
  logic [TS_W-1:0]   wr_ts;

  function automatic logic [ENTRY_W-1:0] pack_entry(input logic [TS_W-1:0] ts,
                                                    input logic [GRP_W-1:0] pat,
                                                    input logic [GIDX_W-1:0] g);
    return {ts, pat, g};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (mask_we) mask_q <= mask_wdata;
  end
  assign mask_rdata = mask_q;

  assign sample_ok = sample && !scan_busy && !reading && !clear;
  assign rd_go     = rd_start && !scan_busy;

  hrb_sync #(.W(NPIX)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(hit_in), .d_out(hits_sync));

  hrb_scan #(.NPIX(NPIX), .GRP_W(GRP_W), .TS_W(TS_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .clear(clear), .start(sample_ok),
    .override_en(override_en), .hits(hits_sync), .mask(mask_q), .ts_in(ts_in),
    .busy(scan_busy), .wr_en(wr_en), .wr_pat(wr_pat), .wr_gidx(wr_gidx),
    .wr_ts(wr_ts));

  hrb_slots #(.SLOTS(SLOTS), .ENTRY_W(ENTRY_W), .ROW_W(ROW_W), .ROW_ADDR(ROW_ADDR)) u_slots (
    .clk(clk), .rst_n(rst_n), .clear(clear), .wr_en(wr_en),
    .wr_entry(pack_entry(wr_ts, wr_pat, wr_gidx)), .rd_start(rd_go),
    .out_ready(out_ready), .reading(reading), .overflow(overflow),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .rd_done(rd_done));

  assert_scan_read_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(scan_busy && reading));
  assert_busy_strobe_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    scan_busy && sample && !clear |=> $stable(wr_ts));
  assert_masked_bits_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sample_ok |=> (u_scan.frozen & $past(mask_q)) == '0);
endmodule

// File: tb/tb_hit_row_buffer.sv
module tb_hit_row_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int NPIX = 42;
  localparam int SLOTS = 19;
  localparam logic [7:0] ROW = 8'h2A;

  logic clk = 0, rst_n = 0;
  logic [NPIX-1:0] hit_in = '0, mask_wdata = '0, mask_rdata;
  logic sample = 0, override_en = 0, mask_we = 0, clear = 0, rd_start = 0, out_ready = 0;
  logic [12:0] ts_in = '0;
  logic out_valid, out_last, rd_done, overflow;
  logic [29:0] out_data;

  int n_tests = 0, n_fail = 0;
  logic [21:0] exp_mem [32];
  int exp_cnt = 0;
  bit exp_ovf = 0;
  logic [NPIX-1:0] cur_mask = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hit_row_buffer dut (.clk(clk), .rst_n(rst_n), .hit_in(hit_in), .sample(sample),
    .ts_in(ts_in), .override_en(override_en), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .mask_rdata(mask_rdata), .clear(clear), .rd_start(rd_start), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last), .rd_done(rd_done),
    .overflow(overflow));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic model_add(input logic [NPIX-1:0] h, input logic [12:0] ts, input bit ovr);
    for (int g = 0; g < 7; g++) begin
      logic [5:0] pat;
      pat = 6'(((h & ~cur_mask) >> (g*6)) & 42'h3F);
      if (ovr || pat != 0) begin
        if (exp_cnt < SLOTS) begin
          exp_mem[exp_cnt] = {ts, pat, 3'(g)};
          exp_cnt++;
        end else exp_ovf = 1;
      end
    end
  endtask

  task automatic pulse_sample(input logic [12:0] ts);
    sample = 1; ts_in = ts;
    @(negedge clk);
    sample = 0;
  endtask

  task automatic take_sample(input logic [NPIX-1:0] h, input logic [12:0] ts, input bit ovr);
    hit_in = h; override_en = ovr;
    wait_n(3);
    pulse_sample(ts);
    model_add(h, ts, ovr);
    wait_n(9);
    override_en = 0;
  endtask

  task automatic do_clear();
    clear = 1; @(negedge clk); clear = 0;
    exp_cnt = 0; exp_ovf = 0;
  endtask

  // Reads out and compares with the model (R7, R8, R9, R13); drains the model.
  task automatic read_check(input int stall, input bit samp_during);
    int nb;
    bit got_done;
    logic [29:0] first;
    nb = 0; got_done = 0;
    rd_start = 1; out_ready = (stall == 0);
    @(negedge clk);
    rd_start = 0;
    first = {ROW, exp_mem[exp_cnt > 0 ? exp_cnt-1 : 0]};
    for (int s = 0; s < stall; s++) begin
      chk(out_valid === 1'b1 && out_data === first, "R8 stall hold", out_data, first);
      if (s == 0 && samp_during) begin hit_in = '1; sample = 1; ts_in = 13'h1FFF; end
      else sample = 0;
      @(negedge clk);
    end
    sample = 0; out_ready = 1;
    for (int c = 0; c < 60; c++) begin
      if (out_valid) begin
        logic [29:0] e;
        e = {ROW, exp_mem[exp_cnt-1-nb]};
        chk(out_data === e, "R7 beat data", out_data, e);
        chk(out_last === (nb == exp_cnt-1), "R7 last flag", out_last, (nb == exp_cnt-1));
        nb++;
        @(negedge clk);
      end else if (rd_done) begin
        got_done = 1;
        break;
      end else @(negedge clk);
    end
    chk(got_done, "R13 rd_done after final beat / R9 empty done", got_done, 1);
    chk(nb == exp_cnt, "R7 beat count", nb, exp_cnt);
    chk(overflow === exp_ovf, "R5 overflow flag", overflow, exp_ovf);
    @(negedge clk);
    chk(rd_done === 1'b0, "R13 done one cycle", rd_done, 0);
    exp_cnt = 0;
    out_ready = 0;
  endtask

  initial begin
    wait_n(3);
    rst_n = 1;
    wait_n(1);
    chk(out_valid === 0 && rd_done === 0, "R12 reset outputs", {out_valid, rd_done}, 0);
    chk(overflow === 0, "R5 reset overflow", overflow, 0);
    chk(mask_rdata === '0, "R11 reset mask", mask_rdata, 0);

    // R9 empty readout
    read_check(0, 0);

    // R1 R2 R3 single hits at the row ends
    take_sample(42'd1 << 13, 13'h1ABC, 0);
    read_check(0, 0);
    do_clear();
    take_sample(42'd1 << 0, 13'h0005, 0);
    take_sample(42'd1 << 41, 13'h1F00, 0);
    read_check(1, 0);
    do_clear();

    // R2 R3 R7 R8 pattern sweep
    for (int r = 0; r < 4; r++) begin
      for (int s = 0; s < 2; s++) begin
        logic [NPIX-1:0] h;
        for (int p = 0; p < NPIX; p++) h[p] = ((p*(r+3) + s*5 + r) % 11) == 0;
        take_sample(h, 13'(r*977 + s*131 + 7), 0);
      end
      read_check(r % 3, 0);
      do_clear();
    end

    // R5 overflow: 3 full rows = 21 entries, 19 kept
    for (int s = 0; s < 3; s++) take_sample('1, 13'(100 + s), 0);
    chk(overflow === 1'b1, "R5 overflow set", overflow, 1);
    read_check(0, 0);
    // R12 clear
    do_clear();
    chk(overflow === 1'b0, "R12 clear overflow", overflow, 0);
    read_check(0, 0);

    // R10 override: all groups with zero patterns
    take_sample('0, 13'h0A5A, 1);
    take_sample(42'd1 << 20, 13'h15A5, 1);
    read_check(2, 0);
    do_clear();

    // R11 mask load, readback, masking
    mask_wdata = 42'h3F | (42'h3F << 18); mask_we = 1;
    @(negedge clk); mask_we = 0; mask_wdata = '0;
    cur_mask = 42'h3F | (42'h3F << 18);
    chk(mask_rdata === cur_mask, "R11 mask readback", mask_rdata, cur_mask);
    take_sample(42'h21 | (42'h5 << 18), 13'h0777, 0);
    read_check(0, 0);
    take_sample(42'h3 | (42'h3 << 6) | (42'h1 << 40), 13'h0888, 0);
    read_check(0, 0);
    do_clear();
    mask_we = 1; @(negedge clk); mask_we = 0; cur_mask = '0;

    // R4 strobes during a scan
    hit_in = 42'h3 << 12;
    wait_n(3);
    pulse_sample(13'h0100);
    model_add(42'h3 << 12, 13'h0100, 0);
    hit_in = 42'h1 << 30;
    wait_n(2);
    pulse_sample(13'h0333);
    wait_n(3);
    pulse_sample(13'h0777);
    pulse_sample(13'h0888);
    model_add(42'h1 << 30, 13'h0888, 0);
    wait_n(9);
    read_check(0, 0);
    do_clear();

    // R4 strobe during readout is ignored
    take_sample(42'h1 << 7, 13'h0042, 0);
    take_sample(42'h1 << 9, 13'h0043, 0);
    read_check(2, 1);
    wait_n(10);
    read_check(0, 0);
    do_clear();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule